// File: doc/BRIEF.md
# Flash interrupt and status unit

This unit keeps the event and error bookkeeping of a memory-mapped flash interface. It holds the interrupt status register, the controller status register and two system configuration registers. It sits between the host register port and a separate command engine. Host writes to the command register are screened and decoded here. Accepted commands are handed to the engine as a one-cycle issue pulse. The engine reports back with completion pulses and error flags, and these are folded into the status registers.

The host clears events by writing an AND mask to the interrupt register. When the master interrupt bit ends up clear after such a write, every latched error bit is wiped as well. While the master bit is set, a write to the command register is discarded without any sign. Software must therefore acknowledge one operation before it starts the next.

The interrupt pin is derived from the master bit and a polarity bit in configuration register 1. The ready pin is a copy of another bit of that register, taken at each write to it. The reset commands perform a warm reset of all these registers. Any command code the unit does not recognise is reported as a command error.

Top module: `flash_irq_status`

## Requirements
- R1: After a cold reset, configuration 1 reads 0x40C0, configuration 2 reads 0, status reads 0, interrupt status reads 0x8080, and the ready output is 1. Register select codes are: command 0, configuration 1 = 1, configuration 2 = 2, status 3, interrupt 4.
- R2: Configuration 2 reads back the full 16 written bits. Configuration 1 reads back the stored value with bits 4:0 forced to zero.
- R3: irq_o equals interrupt bit 15 XOR the inverse of configuration 1 bit 6. A 1 in bit 6 makes the output active high, and a 0 makes it active low. irq_o follows register changes combinationally.
- R4: On every write to configuration 1, rdy_o takes the written bit 7 from the next cycle on.
- R5: A completion pulse sets its event bit and interrupt bit 15 on the next clock edge. done_i[0] (reset) maps to bit 4, done_i[1] (erase) to bit 5, done_i[2] (program) to bit 6 and done_i[3] (load) to bit 7. An error flag is ORed into status on the same edge. err_i[0] (command) maps to bit 10, err_i[1] (erase) to bit 11, err_i[2] (program) to bit 12 and err_i[3] (load) to bit 13.
- R6: A write to the interrupt register ANDs the data into interrupt status. If bit 15 of the masked result is 0, status bits 13:10 are cleared. Events and errors arriving in the same cycle are applied after the mask and the wipe, so they are kept.
- R7: A command write is dropped while interrupt bit 15 is set. No issue pulse is produced, and the command register and all other registers keep their values.
- R8: A recognised command written while bit 15 is clear is stored in the command register. It also produces a one-cycle cmd_issue_o pulse with the code on cmd_code_o, in the cycle after the write. The recognised codes are 0x00, 0x13, 0x80, 0x1A, 0x1B, 0x23, 0x27, 0x2A, 0x2C, 0x71, 0x94, 0x95, 0xB0, 0x30, 0x65, 0xF0 and 0xF3.
- R9: An unrecognised command code that is accepted sets status bit 10 and interrupt bit 15, and it produces no issue pulse.
- R10: An accepted command 0xF0 or 0xF3 performs a warm reset: configuration 1 = 0x40C0, configuration 2 = 0, status = 0, interrupt status = 0x8010, command register = 0, and ready = 1.
- R11: Writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low cold reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for the write |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 3 | Register select for the read |
| rd_data_o | output | 16 | Read data, combinational |
| done_i | input | 4 | Completion pulses from the command engine: reset, erase, program, load |
| err_i | input | 4 | Error flags from the command engine: command, erase, program, load |
| cmd_issue_o | output | 1 | One-cycle pulse for an accepted, recognised command |
| cmd_code_o | output | 16 | Code of the issued command |
| irq_o | output | 1 | Interrupt output with programmable polarity |
| rdy_o | output | 1 | Ready output |

## Verification
An acknowledge write to the interrupt register can land in the same cycle as a completion pulse and an error flag from the engine. The bench provokes this on purpose. It first latches a program error under a pending load event. It then drives a clearing mask together with an erase completion and an erase error in one cycle. It expects interrupt status 0x8020 and status 0x0800: the old error is wiped and the new event and error survive. A second check acknowledges with bit 15 kept set and expects the latched error to stay.

// File: rtl/fis_pkg.sv
// Shared constants and helpers for the flash interrupt and status unit.
// Assumes 16-bit registers and four event and four error kinds.
package fis_pkg;
    localparam int DATA_W      = 16;
    localparam int EVT_N       = 4;
    localparam int SEL_W       = 3;
    localparam int MASTER_BIT  = 15;
    localparam int EVT_LSB     = 4;
    localparam int ERR_LSB     = 10;
    localparam int POL_BIT     = 6;
    localparam int RDY_BIT     = 7;
    localparam int CFG1_RD_LOW = 5;

    localparam logic [DATA_W-1:0] CFG1_RST  = 16'h40C0;
    localparam logic [DATA_W-1:0] CFG2_RST  = 16'h0000;
    localparam logic [DATA_W-1:0] INT_COLD  = 16'h8080;
    localparam logic [DATA_W-1:0] INT_WARM  = 16'h8010;
    localparam logic [DATA_W-1:0] ERR_MASK  = {{(DATA_W-ERR_LSB-EVT_N){1'b0}},
                                               {EVT_N{1'b1}}, {ERR_LSB{1'b0}}};
    localparam logic [DATA_W-1:0] CFG1_RD_MASK = {{(DATA_W-CFG1_RD_LOW){1'b1}},
                                                  {CFG1_RD_LOW{1'b0}}};

    typedef enum logic [SEL_W-1:0] {
        SEL_CMD  = 3'd0,
        SEL_CFG1 = 3'd1,
        SEL_CFG2 = 3'd2,
        SEL_STAT = 3'd3,
        SEL_INT  = 3'd4
    } reg_sel_e;

    // True when the code is one the command engine understands.
    function automatic logic cmd_known(input logic [DATA_W-1:0] c);
        case (c)
            16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B,
            16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0071,
            16'h0094, 16'h0095, 16'h00B0, 16'h0030, 16'h0065,
            16'h00F0, 16'h00F3: return 1'b1;
            default:            return 1'b0;
        endcase
    endfunction

    // True for the two codes that warm-reset the register set.
    function automatic logic cmd_is_reset(input logic [DATA_W-1:0] c);
        return (c == 16'h00F0) || (c == 16'h00F3);
    endfunction
endpackage

// File: rtl/fis_cmd_gate.sv
// Command screening: accepts a command write only while the master
// interrupt bit is clear, classifies it and issues it to the engine.
// Assumes a single write port, so no other write shares the cycle.
module fis_cmd_gate
    import fis_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              master_i,
    output logic              unknown_o,
    output logic              warm_o,
    output logic [DATA_W-1:0] cmd_q_o,
    output logic              cmd_issue_o,
    output logic [DATA_W-1:0] cmd_code_o
);
    logic accept;
    logic known;

    // Decode the write and qualify it with the pending interrupt.
    always_comb begin
        accept    = wr_en_i && (wr_sel_i == SEL_CMD) && !master_i;
        known     = cmd_known(wr_data_i);
        unknown_o = accept && !known;
        warm_o    = accept && cmd_is_reset(wr_data_i);
    end

    // Command register, issue pulse and issued code.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cmd_q_o     <= '0;
            cmd_issue_o <= 1'b0;
            cmd_code_o  <= '0;
        end else begin
            cmd_issue_o <= accept && known;
            if (accept) begin
                cmd_code_o <= wr_data_i;
                cmd_q_o    <= cmd_is_reset(wr_data_i) ? '0 : wr_data_i;
            end
        end
    end
endmodule

// File: rtl/fis_event_regs.sv
// Interrupt status and controller status registers. Applies the
// acknowledge mask first, then the error wipe, then new events, errors
// and the unknown-command error, so nothing arriving in the cycle is lost.
module fis_event_regs
    import fis_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              warm_i,
    input  logic              unknown_i,
    input  logic              ack_en_i,
    input  logic [DATA_W-1:0] ack_data_i,
    input  logic [EVT_N-1:0]  done_i,
    input  logic [EVT_N-1:0]  err_i,
    output logic [DATA_W-1:0] int_q_o,
    output logic [DATA_W-1:0] stat_q_o
);
    logic [DATA_W-1:0] int_nxt;
    logic [DATA_W-1:0] stat_nxt;
    logic              wipe;

    // Next-state for both registers in the fixed order of application.
    always_comb begin
        int_nxt  = int_q_o;
        stat_nxt = stat_q_o;
        wipe     = 1'b0;
        if (ack_en_i) begin
            int_nxt = int_q_o & ack_data_i;
            wipe    = !int_nxt[MASTER_BIT];
        end
        if (wipe) begin
            stat_nxt = stat_nxt & ~ERR_MASK;
        end
        for (int i = 0; i < EVT_N; i++) begin
            if (done_i[i]) begin
                int_nxt[EVT_LSB+i]  = 1'b1;
                int_nxt[MASTER_BIT] = 1'b1;
            end
            if (err_i[i]) begin
                stat_nxt[ERR_LSB+i] = 1'b1;
            end
        end
        if (unknown_i) begin
            stat_nxt[ERR_LSB]   = 1'b1;
            int_nxt[MASTER_BIT] = 1'b1;
        end
    end

    // Register update with cold and warm reset values.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            int_q_o  <= INT_COLD;
            stat_q_o <= '0;
        end else if (warm_i) begin
            int_q_o  <= INT_WARM;
            stat_q_o <= '0;
        end else begin
            int_q_o  <= int_nxt;
            stat_q_o <= stat_nxt;
        end
    end
endmodule

// File: rtl/fis_cfg_regs.sv
// System configuration registers 1 and 2 and the ready output.
// Ready is raised by any reset and otherwise copies the ready bit of
// each configuration 1 write.
module fis_cfg_regs
    import fis_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              warm_i,
    input  logic              wr_cfg1_i,
    input  logic              wr_cfg2_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] cfg1_q_o,
    output logic [DATA_W-1:0] cfg2_q_o,
    output logic              rdy_o
);
    // Configuration storage and ready tracking.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || warm_i) begin
            cfg1_q_o <= CFG1_RST;
            cfg2_q_o <= CFG2_RST;
            rdy_o    <= 1'b1;
        end else begin
            if (wr_cfg1_i) begin
                cfg1_q_o <= wr_data_i;
                rdy_o    <= wr_data_i[RDY_BIT];
            end
            if (wr_cfg2_i) begin
                cfg2_q_o <= wr_data_i;
            end
        end
    end
endmodule

// File: rtl/flash_irq_status.sv
// Top of the flash interrupt and status unit. Ties the command gate,
// event registers and configuration registers together, drives the
// read multiplexer and the polarity-programmable interrupt output.
// Assumes the command engine pulses done_i and err_i for one cycle.
module flash_irq_status
    import fis_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [SEL_W-1:0]  rd_sel_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [EVT_N-1:0]  done_i,
    input  logic [EVT_N-1:0]  err_i,
    output logic              cmd_issue_o,
    output logic [DATA_W-1:0] cmd_code_o,
    output logic              irq_o,
    output logic              rdy_o
);
    logic [DATA_W-1:0] int_w;
    logic [DATA_W-1:0] stat_w;
    logic [DATA_W-1:0] cfg1_w;
    logic [DATA_W-1:0] cfg2_w;
    logic [DATA_W-1:0] cmd_w;
    logic              unknown_w;
    logic              warm_w;
    logic              ack_en_w;
    logic              wr_cfg1_w;
    logic              wr_cfg2_w;

    // Per-register write strobes.
    always_comb begin
        ack_en_w  = wr_en_i && (wr_sel_i == SEL_INT);
        wr_cfg1_w = wr_en_i && (wr_sel_i == SEL_CFG1);
        wr_cfg2_w = wr_en_i && (wr_sel_i == SEL_CFG2);
    end

    fis_cmd_gate u_gate (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (wr_en_i),
        .wr_sel_i    (wr_sel_i),
        .wr_data_i   (wr_data_i),
        .master_i    (int_w[MASTER_BIT]),
        .unknown_o   (unknown_w),
        .warm_o      (warm_w),
        .cmd_q_o     (cmd_w),
        .cmd_issue_o (cmd_issue_o),
        .cmd_code_o  (cmd_code_o)
    );

    fis_event_regs u_evt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .warm_i     (warm_w),
        .unknown_i  (unknown_w),
        .ack_en_i   (ack_en_w),
        .ack_data_i (wr_data_i),
        .done_i     (done_i),
        .err_i      (err_i),
        .int_q_o    (int_w),
        .stat_q_o   (stat_w)
    );

    fis_cfg_regs u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .warm_i    (warm_w),
        .wr_cfg1_i (wr_cfg1_w),
        .wr_cfg2_i (wr_cfg2_w),
        .wr_data_i (wr_data_i),
        .cfg1_q_o  (cfg1_w),
        .cfg2_q_o  (cfg2_w),
        .rdy_o     (rdy_o)
    );

    // Register read multiplexer.
    always_comb begin
        case (rd_sel_i)
            SEL_CMD:  rd_data_o = cmd_w;
            SEL_CFG1: rd_data_o = cfg1_w & CFG1_RD_MASK;
            SEL_CFG2: rd_data_o = cfg2_w;
            SEL_STAT: rd_data_o = stat_w;
            SEL_INT:  rd_data_o = int_w;
            default:  rd_data_o = '0;
        endcase
    end

    // Interrupt pin: master bit with programmable polarity.
    always_comb begin
        irq_o = int_w[MASTER_BIT] ^ ~cfg1_w[POL_BIT];
    end
endmodule

// File: rtl/fis_checker.sv
// Temporal checks for the flash interrupt and status unit, bound to
// the top module. Observes ports and the internal register values.
module fis_checker
    import fis_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [SEL_W-1:0]  wr_sel_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [EVT_N-1:0]  done_i,
    input logic [EVT_N-1:0]  err_i,
    input logic [DATA_W-1:0] int_v,
    input logic [DATA_W-1:0] stat_v,
    input logic [DATA_W-1:0] cfg1_v,
    input logic              irq_o,
    input logic              rdy_o,
    input logic              cmd_issue_o
);
    logic cmd_wr;
    logic cmd_open;
    always_comb begin
        cmd_wr   = wr_en_i && (wr_sel_i == SEL_CMD);
        cmd_open = cmd_wr && !int_v[MASTER_BIT];
    end

    AST_IRQ_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg1_v[POL_BIT] ? (irq_o == int_v[MASTER_BIT]) : (irq_o != int_v[MASTER_BIT])); // R3

    AST_RDY_TRACKS_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_sel_i == SEL_CFG1) |=> (rdy_o == $past(wr_data_i[RDY_BIT]))); // R4

    AST_DONE_SETS_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|done_i) && !cmd_wr) |=> (int_v[MASTER_BIT]
            && ((int_v[EVT_LSB +: EVT_N] & $past(done_i)) == $past(done_i)))); // R5

    AST_ERR_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|err_i) && !cmd_wr) |=> ((stat_v[ERR_LSB +: EVT_N] & $past(err_i)) == $past(err_i))); // R5

    AST_ACK_WIPES_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_sel_i == SEL_INT && !wr_data_i[MASTER_BIT] && err_i == '0)
        |=> (stat_v == '0)); // R6

    AST_CMD_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_wr && int_v[MASTER_BIT]) |=> !cmd_issue_o); // R7

    AST_UNKNOWN_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_open && !cmd_known(wr_data_i)) |=> (stat_v[ERR_LSB] && int_v[MASTER_BIT] && !cmd_issue_o)); // R9

    AST_WARM_VALUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_open && cmd_is_reset(wr_data_i)) |=> (int_v == INT_WARM && stat_v == '0 && rdy_o)); // R10
endmodule

bind flash_irq_status fis_checker u_fis_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .done_i      (done_i),
    .err_i       (err_i),
    .int_v       (int_w),
    .stat_v      (stat_w),
    .cfg1_v      (cfg1_w),
    .irq_o       (irq_o),
    .rdy_o       (rdy_o),
    .cmd_issue_o (cmd_issue_o)
);

// File: tb/flash_irq_status_bench.sv
`timescale 1ns/1ps
module flash_irq_status_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic [3:0]  done = '0;
    logic [3:0]  err = '0;
    logic        cmd_issue;
    logic [15:0] cmd_code;
    logic        irq;
    logic        rdy;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    localparam logic [2:0] S_CMD = 3'd0, S_CFG1 = 3'd1, S_CFG2 = 3'd2,
                           S_STAT = 3'd3, S_INT = 3'd4;

    always #4 clk = ~clk;

    flash_irq_status u_flash_irq_status (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
        .done_i(done), .err_i(err), .cmd_issue_o(cmd_issue),
        .cmd_code_o(cmd_code), .irq_o(irq), .rdy_o(rdy)
    );

    // Vector: write select, write data, read select, expected read, requirement number
    typedef struct packed {
        logic [2:0]  ws;
        logic [15:0] wd;
        logic [2:0]  rs;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{S_CFG2, 16'h1234, S_CFG2, 16'h1234, 8'd2},   // R2 full readback
        '{S_CFG1, 16'h40DF, S_CFG1, 16'h40C0, 8'd2},   // R2 low bits masked
        '{S_INT,  16'h00FF, S_INT,  16'h0080, 8'd6},   // R6 AND mask
        '{S_INT,  16'h0000, S_INT,  16'h0000, 8'd6},   // R6 clear all
        '{S_CMD,  16'h0094, S_CMD,  16'h0094, 8'd8},   // R8 stored
        '{S_STAT, 16'hFFFF, S_STAT, 16'h0000, 8'd11},  // R11 ignored
        '{S_CMD,  16'h0055, S_STAT, 16'h0400, 8'd9},   // R9 command error
        '{S_CMD,  16'h0013, S_CMD,  16'h0055, 8'd7},   // R7 blocked
        '{S_INT,  16'h7FFF, S_INT,  16'h0000, 8'd6},   // R6 master cleared
        '{S_CFG2, 16'h0000, S_STAT, 16'h0000, 8'd6}    // R6 errors wiped
    };

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] s, input logic [15:0] exp,
                          input string req, input string what);
        rd_sel = s;
        #1;
        chk(req, what, rd_data, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic reset_checks();
        rd_chk(S_CFG1, 16'h40C0, "R1", "cfg1 reset");
        rd_chk(S_CFG2, 16'h0000, "R1", "cfg2 reset");
        rd_chk(S_STAT, 16'h0000, "R1", "status reset");
        rd_chk(S_INT,  16'h8080, "R1", "int reset");
        chk("R1", "rdy reset", {15'd0, rdy}, 16'd1);
        chk("R3", "irq after reset", {15'd0, irq}, 16'd1);
    endtask

    initial begin
        do_reset();
        reset_checks();

        // Vector walk
        for (int i = 0; i < 10; i++) begin
            wr(VECS[i].ws, VECS[i].wd);
            rd_chk(VECS[i].rs, VECS[i].exp, $sformatf("R%0d", VECS[i].req),
                   $sformatf("vector %0d", i));
        end

        // R3 polarity: master clear now, cfg1 bit6 set
        chk("R3", "irq high-pol idle", {15'd0, irq}, 16'd0);
        wr(S_CFG1, 16'h0080);
        chk("R3", "irq low-pol idle", {15'd0, irq}, 16'd1);

        // R4 ready follows bit 7
        wr(S_CFG1, 16'h4040);
        chk("R4", "rdy cleared", {15'd0, rdy}, 16'd0);
        wr(S_CFG1, 16'h40C0);
        chk("R4", "rdy set", {15'd0, rdy}, 16'd1);

        // R8 issue pulse
        wr(S_CMD, 16'h0080);
        chk("R8", "issue pulse", {15'd0, cmd_issue}, 16'd1);
        chk("R8", "issue code", cmd_code, 16'h0080);
        @(negedge clk);
        chk("R8", "issue one cycle", {15'd0, cmd_issue}, 16'd0);

        // R5 completion with error
        done = 4'b1000; err = 4'b0100;
        @(negedge clk);
        done = '0; err = '0;
        rd_chk(S_INT,  16'h8080, "R5", "load event");
        rd_chk(S_STAT, 16'h1000, "R5", "program error");
        chk("R3", "irq on event", {15'd0, irq}, 16'd1);

        // R7 reset command dropped while pending
        wr(S_CMD, 16'h00F0);
        chk("R7", "no issue when blocked", {15'd0, cmd_issue}, 16'd0);
        rd_chk(S_CMD, 16'h0080, "R7", "cmd unchanged");
        rd_chk(S_INT, 16'h8080, "R7", "int unchanged");

        // R6 ack with same-cycle event and error
        @(negedge clk);
        wr_en = 1'b1; wr_sel = S_INT; wr_data = 16'h0000;
        done = 4'b0010; err = 4'b0010;
        @(negedge clk);
        wr_en = 1'b0; done = '0; err = '0;
        rd_chk(S_INT,  16'h8020, "R6", "same-cycle event kept");
        rd_chk(S_STAT, 16'h0800, "R6", "old error wiped, new kept");

        // R6 ack keeping master leaves errors
        wr(S_INT, 16'hFFDF);
        rd_chk(S_INT,  16'h8000, "R6", "partial ack");
        rd_chk(S_STAT, 16'h0800, "R6", "errors kept with master");
        wr(S_INT, 16'h0000);
        rd_chk(S_STAT, 16'h0000, "R6", "errors wiped");

        // R10 warm reset command
        wr(S_CFG2, 16'h5555);
        wr(S_CFG1, 16'h0000);
        chk("R4", "rdy low before warm", {15'd0, rdy}, 16'd0);
        wr(S_CMD, 16'h00F3);
        chk("R10", "reset cmd issued", {15'd0, cmd_issue}, 16'd1);
        rd_chk(S_INT,  16'h8010, "R10", "int warm");
        rd_chk(S_CFG1, 16'h40C0, "R10", "cfg1 warm");
        rd_chk(S_CFG2, 16'h0000, "R10", "cfg2 warm");
        rd_chk(S_STAT, 16'h0000, "R10", "status warm");
        rd_chk(S_CMD,  16'h0000, "R10", "cmd warm");
        chk("R10", "rdy warm", {15'd0, rdy}, 16'd1);

        // R1 cold reset again
        do_reset();
        reset_checks();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule